// File: doc/BRIEF.md
# Programming Mode Entry Sequencer

This block sits on the programmer side of a serial programming link and brings a target device into its program/verify mode. It drives three lines toward the target: an active-low reset, a serial data line and a serial clock. When it receives a one-cycle start request, it releases reset for a short kick and then asserts it again. It then waits a programmable gap and clocks a fixed 32-bit unlock key out on the data line. After the key it releases reset for good, waits a programmable settle interval and raises a ready flag.

Every interval is a cycle count taken from a parameter, and a down-counter enforces each one before the sequencer moves on. The serial clock comes from a programmable half-period divider. Each key bit is placed on the data line while the clock is low and stays unchanged through the high phase, so the target samples it on the rising edge. An abort input returns the sequencer to idle from any state, which asserts the target reset again and parks the clock and data lines low.

All outputs are registered, so each output follows the internal state with a latency of one cycle.

Top module: `pme_entry_seq`

## Requirements
- R1: After the synchronous reset and while idle, the reset line to the target is low, the serial clock and data lines are low, and ready is low.
- R2: A start pulse while idle releases the target reset (output high) for exactly KICK_CYC cycles and then drives it low again.
- R3: The first rising edge of the serial clock comes exactly GAP_CYC + HALF_CYC cycles after the target reset falls at the end of the kick, which gives at least GAP_CYC cycles before the first key bit.
- R4: The bits on the data line at the 32 rising clock edges form the value 0x4D434850, most significant bit first.
- R5: During the key, every clock high phase and every low phase between bits lasts HALF_CYC cycles, and the data line does not change while the clock is high.
- R6: The target reset rises exactly RELEASE_CYC cycles after the last falling clock edge of the key, and it stays high through settle and ready.
- R7: Ready rises exactly SETTLE_CYC cycles after the target reset rises, and it is never high while the target reset is low.
- R8: The serial clock and data lines are low whenever no key is being shifted, and the clock is never high while the target reset is high.
- R9: An abort drives the target reset, clock, data and ready low two cycles after it is sampled, whatever the state, and the block then stays idle.
- R10: A start request is ignored while a sequence is in progress or while ready is high: the key still comes out intact and the ready state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the entry sequence (accepted only while idle) |
| abort_i | input | 1 | Return to idle from any state |
| tgt_rst_n_o | output | 1 | Active-low reset line to the target |
| sclk_o | output | 1 | Serial clock to the target |
| sdat_o | output | 1 | Serial data to the target |
| ready_o | output | 1 | Target is in program/verify mode |

## Verification
The bound checker watches the ordering rules on every cycle. Ready may only be high with the target reset released, and only after the reset has been high for at least the settle count. The clock may only toggle while the target reset is asserted, and only after a low run at least as long as the gap. Data must hold steady through each clock-high phase, and an abort must leave every output low two cycles later. The directed scenarios are the only way to show the exact widths of the kick pulse, the gap, the clock phases and the release delay, the key value collected bit by bit, and the handling of start requests that arrive mid-sequence or in the ready state.

// File: rtl/pme_pkg.sv
package pme_pkg;

  localparam int unsigned KEY_W = 32;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 32'h4D434850;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KICK,
    S_GAP,
    S_KEY,
    S_RELEASE,
    S_SETTLE,
    S_READY
  } pme_state_e;

endpackage

// File: rtl/pme_interval.sv
module pme_interval #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pme_bitclk.sv
module pme_bitclk #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic high_o,
  output logic wrap_o
);

  localparam int unsigned PERIOD = 2 * HALF_CYC;
  localparam int unsigned PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(PERIOD - 1);
  localparam logic [PW-1:0] HIGH_PH = PW'(HALF_CYC);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      phase_q <= '0;
    end else if (run_i) begin
      if (phase_q == LAST_PH) phase_q <= '0;
      else                    phase_q <= phase_q + 1'b1;
    end
  end

  assign high_o = (phase_q >= HIGH_PH);
  assign wrap_o = (phase_q == LAST_PH);

endmodule

// File: rtl/pme_keyreg.sv
module pme_keyreg #(
  parameter int unsigned          KW  = 32,
  parameter logic [KW-1:0]        KEY = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic shift_i,
  output logic bit_o,
  output logic last_o
);

  localparam int unsigned IW = (KW > 1) ? $clog2(KW) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(KW - 1);

  logic [KW-1:0] sr_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= KEY;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[KW-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sr_q[KW-1];
  assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/pme_entry_seq.sv
module pme_entry_seq
  import pme_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned KICK_CYC    = 4,
  parameter int unsigned GAP_CYC     = 10,
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned RELEASE_CYC = 3,
  parameter int unsigned SETTLE_CYC  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic abort_i,
  output logic tgt_rst_n_o,
  output logic sclk_o,
  output logic sdat_o,
  output logic ready_o
);

  localparam logic [CW-1:0] KICK_LD    = CW'(KICK_CYC - 1);
  localparam logic [CW-1:0] GAP_LD     = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] RELEASE_LD = CW'(RELEASE_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LD  = CW'(SETTLE_CYC - 1);

  pme_state_e    state_q, state_d;
  logic          t_load, t_done;
  logic [CW-1:0] t_val;
  logic          key_load, key_shift, key_bit, key_last;
  logic          ck_clr, ck_run, ck_high, ck_wrap;

  logic rst_n_q, sclk_q, sdat_q, ready_q;

  pme_interval #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (t_load),
    .val_i  (t_val),
    .done_o (t_done)
  );

  pme_bitclk #(.HALF_CYC(HALF_CYC)) u_bitclk (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (ck_clr),
    .run_i  (ck_run),
    .high_o (ck_high),
    .wrap_o (ck_wrap)
  );

  pme_keyreg #(.KW(KEY_W), .KEY(UNLOCK_KEY)) u_key (
    .clk     (clk),
    .rst     (rst),
    .load_i  (key_load),
    .shift_i (key_shift),
    .bit_o   (key_bit),
    .last_o  (key_last)
  );

  assign ck_run    = (state_q == S_KEY);
  assign key_shift = (state_q == S_KEY) && ck_wrap;

  always_comb begin
    state_d  = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    key_load = 1'b0;
    ck_clr   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_KICK;
          t_load  = 1'b1;
          t_val   = KICK_LD;
        end
      end
      S_KICK: begin
        if (t_done) begin
          state_d = S_GAP;
          t_load  = 1'b1;
          t_val   = GAP_LD;
        end
      end
      S_GAP: begin
        if (t_done) begin
          state_d  = S_KEY;
          key_load = 1'b1;
          ck_clr   = 1'b1;
        end
      end
      S_KEY: begin
        if (ck_wrap && key_last) begin
          state_d = S_RELEASE;
          t_load  = 1'b1;
          t_val   = RELEASE_LD;
        end
      end
      S_RELEASE: begin
        if (t_done) begin
          state_d = S_SETTLE;
          t_load  = 1'b1;
          t_val   = SETTLE_LD;
        end
      end
      S_SETTLE: begin
        if (t_done) state_d = S_READY;
      end
      S_READY: state_d = S_READY;
      default: state_d = S_IDLE;
    endcase
    if (abort_i) state_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_q <= 1'b0;
      sclk_q  <= 1'b0;
      sdat_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      rst_n_q <= (state_q == S_KICK) || (state_q == S_SETTLE) || (state_q == S_READY);
      sclk_q  <= (state_q == S_KEY) && ck_high;
      sdat_q  <= (state_q == S_KEY) && key_bit;
      ready_q <= (state_q == S_READY);
    end
  end

  assign tgt_rst_n_o = rst_n_q;
  assign sclk_o      = sclk_q;
  assign sdat_o      = sdat_q;
  assign ready_o     = ready_q;

endmodule

// File: rtl/pme_entry_seq_chk.sv
module pme_entry_seq_chk #(
  parameter int unsigned CW         = 16,
  parameter int unsigned GAP_CYC    = 10,
  parameter int unsigned SETTLE_CYC = 12
) (
  input logic clk,
  input logic rst,
  input logic abort_i,
  input logic tgt_rst_n_o,
  input logic sclk_o,
  input logic sdat_o,
  input logic ready_o
);

  logic [CW-1:0] hi_run_q, lo_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      if (tgt_rst_n_o) begin
        lo_run_q <= '0;
        if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
      end else begin
        hi_run_q <= '0;
        if (lo_run_q != '1) lo_run_q <= lo_run_q + 1'b1;
      end
    end
  end

  a_r7_ready_needs_release: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> tgt_rst_n_o);

  a_r7_settle_elapsed: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (hi_run_q >= CW'(SETTLE_CYC)));

  a_r8_clock_only_in_reset: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !tgt_rst_n_o);

  a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!sclk_o && !sdat_o));

  a_r3_gap_before_clock: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> (lo_run_q >= CW'(GAP_CYC)));

  a_r5_data_held_high: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdat_o));

  a_r9_abort_quiets: assert property (@(posedge clk) disable iff (rst)
    abort_i |-> ##2 (!tgt_rst_n_o && !sclk_o && !sdat_o && !ready_o));

endmodule

bind pme_entry_seq pme_entry_seq_chk #(
  .CW(CW), .GAP_CYC(GAP_CYC), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .abort_i     (abort_i),
  .tgt_rst_n_o (tgt_rst_n_o),
  .sclk_o      (sclk_o),
  .sdat_o      (sdat_o),
  .ready_o     (ready_o)
);

// File: tb/pme_entry_seq_bench.sv
module pme_entry_seq_bench;

  localparam int KICK    = 4;
  localparam int GAP     = 10;
  localparam int HALF    = 2;
  localparam int RELEASE = 3;
  localparam int SETTLE  = 12;
  localparam logic [31:0] EXP_KEY = 32'h4D434850;
  localparam int LIMIT   = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic rst_n, sclk, sdat, ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pme_entry_seq #(
    .CW(16), .KICK_CYC(KICK), .GAP_CYC(GAP), .HALF_CYC(HALF),
    .RELEASE_CYC(RELEASE), .SETTLE_CYC(SETTLE)
  ) u_pme_entry_seq (
    .clk(clk), .rst(rst), .start_i(start), .abort_i(abort),
    .tgt_rst_n_o(rst_n), .sclk_o(sclk), .sdat_o(sdat), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit sig(input int w);
    case (w)
      0: return rst_n;
      1: return sclk;
      2: return sdat;
      3: return ready;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_len(input int w, input bit v, output int n);
    n = 0;
    while (sig(w) == v && n < LIMIT) begin
      n++;
      tick();
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(!rst_n && !sclk && !sdat && !ready, "R1", "outputs after reset",
        {rst_n, sclk, sdat, ready}, 0);
    repeat (5) tick();
    chk(!rst_n && !sclk && !sdat && !ready, "R1", "outputs while idle",
        {rst_n, sclk, sdat, ready}, 0);
  endtask

  task automatic t_full_entry(input bit poke);
    int n;
    int hi;
    bit stable;
    bit quiet;
    bit b;
    logic [31:0] key;
    pulse_start();
    run_len(0, 0, n);
    run_len(0, 1, n);
    chk(n == KICK, "R2", "kick width", n, KICK);
    n = 0;
    quiet = 1'b1;
    while (!sclk && n < LIMIT) begin
      if (sdat || rst_n) quiet = 1'b0;
      n++;
      tick();
    end
    chk(n == GAP + HALF, "R3", "reset fall to first clock rise", n, GAP + HALF);
    chk(quiet, "R8", "data and reset low during gap", quiet, 1);
    key = '0;
    for (int i = 0; i < 32; i++) begin
      b = sdat;
      key = {key[30:0], b};
      hi = 0;
      stable = 1'b1;
      while (sclk && hi < LIMIT) begin
        if (sdat != b) stable = 1'b0;
        hi++;
        tick();
      end
      if (i == 0 || i == 31) begin
        chk(hi == HALF, "R5", "clock high width", hi, HALF);
        chk(stable, "R5", "data stable while clock high", stable, 1);
      end else if (hi != HALF || !stable) begin
        chk(1'b0, "R5", "clock high phase", hi, HALF);
      end
      if (i < 31) begin
        if (poke && i == 10) start = 1'b1;
        run_len(1, 0, n);
        start = 1'b0;
        if (n != HALF) chk(1'b0, "R5", "clock low width", n, HALF);
      end
    end
    chk(key == EXP_KEY, "R4", "key captured on rising edges", key, EXP_KEY);
    if (poke) chk(key == EXP_KEY, "R10", "key intact after mid-shift start", key, EXP_KEY);
    run_len(0, 0, n);
    chk(n == RELEASE, "R6", "last clock fall to reset release", n, RELEASE);
    n = 0;
    quiet = 1'b1;
    while (!ready && n < LIMIT) begin
      if (sclk || sdat || !rst_n) quiet = 1'b0;
      n++;
      tick();
    end
    chk(n == SETTLE, "R7", "reset release to ready", n, SETTLE);
    chk(quiet, "R8", "lines quiet and reset high during settle", quiet, 1);
    chk(rst_n, "R6", "reset high at ready", rst_n, 1);
    if (poke) begin
      start = 1'b1;
      tick();
      start = 1'b0;
      quiet = 1'b1;
      for (int k = 0; k < 12; k++) begin
        if (!rst_n || sclk || sdat || !ready) quiet = 1'b0;
        tick();
      end
      chk(quiet, "R10", "ready state held after start", quiet, 1);
    end
  endtask

  task automatic t_abort_in_key();
    int n;
    bit quiet;
    pulse_start();
    n = 0;
    while (!sclk && n < LIMIT) begin n++; tick(); end
    repeat (7) tick();
    abort = 1'b1;
    tick();
    abort = 1'b0;
    tick();
    chk(!rst_n && !sclk && !sdat && !ready, "R9", "outputs two cycles after abort",
        {rst_n, sclk, sdat, ready}, 0);
    quiet = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (rst_n || sclk || sdat || ready) quiet = 1'b0;
      tick();
    end
    chk(quiet, "R9", "stays idle after abort", quiet, 1);
  endtask

  task automatic t_abort_in_ready();
    abort = 1'b1;
    tick();
    abort = 1'b0;
    chk(ready && rst_n, "R9", "outputs unchanged one cycle after abort", {rst_n, ready}, 3);
    tick();
    chk(!rst_n && !ready, "R9", "ready and reset drop after abort", {rst_n, ready}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset();
    t_full_entry(1'b0);
    t_abort_in_ready();
    t_abort_in_key();
    t_full_entry(1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule